// File: doc/BRIEF.md
# Multichannel laser enable and fault controller

This block is the digital control logic of a twelve-channel optical transmitter. Two host control pins, an active-high enable and an active-high inhibit, are reduced to one laser-on decision that all channels share. Each change of that decision takes effect only after a counted delay: a turn-on delay before the lasers light and a turn-off delay before they go dark. Both delays are set as clock-cycle parameters sized to the allowed bounds, 1 ms for turn-on and 510 us for turn-off.

Per-channel fault flags from the analog laser drivers feed a shared fault latch. Once any channel reports a fault, the active-low fault status drops and every channel is forced off at once. The fault stays latched until the host drives an active-low clear pin low for at least a minimum number of cycles. Shorter low pulses are ignored. After an accepted clear is released, the transmitter goes through the normal turn-on delay again. Every asynchronous input passes through a two-flop synchronizer. A ready output shows when the lasers are actually lit.

Top module: `laser_link_ctl`

## Requirements
- R1: All NCH channels share one decision, so `laser_en` is always all zeros or all ones.
- R2: With no fault latched, the lasers can be on only for `tx_enable`=1 and `tx_inhibit`=0. The three other combinations turn them off and keep them off.
- R3: When the request becomes true (enable=1, inhibit=0, no fault, no clear), the lasers turn on exactly ON_CYC+2 rising edges after the input change. The 2 edges are the synchronizer.
- R4: When the request becomes false through enable falling or inhibit rising, the lasers turn off exactly OFF_CYC+2 rising edges after the input change.
- R5: A fault flag on any channel 0..NCH-1 drives `fault_n` low and all of `laser_en` to zero 3 rising edges after the flag rises. This holds whatever the enable and inhibit inputs are.
- R6: A latched fault persists after the channel fault flag drops. While it persists, the lasers stay off even when enable=1 and inhibit=0.
- R7: A clear pulse with `fault_clr_n` low for at least CLR_MIN consecutive edges is accepted: `fault_n` returns high CLR_MIN+3 edges after the pulse starts. A pulse of fewer edges leaves `fault_n` low. While an accepted clear is held low, the lasers stay off.
- R8: After an accepted clear is released, with the request true, the lasers turn on ON_CYC+3 edges after the release.
- R9: `ready` is high exactly when `laser_en` is nonzero.
- R10: While `rst_n` is low, `laser_en` is zero, `ready` is low and `fault_n` is high. After release, the enable value is taken only through the synchronizer, so R3 timing applies from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| tx_enable | input | 1 | Transmit enable, active high (idle level high) |
| tx_inhibit | input | 1 | Transmit inhibit, active high (idle level low) |
| fault_clr_n | input | 1 | Fault clear request, active low, width-filtered |
| ch_fault | input | NCH | Per-channel laser fault flags, active high |
| laser_en | output | NCH | Per-channel laser enable |
| fault_n | output | 1 | Latched fault status, low when a fault is held |
| ready | output | 1 | High while the lasers are lit |

## Verification
The enable and inhibit pins are swept through all four combinations from the lit state. The turn-off latency is measured for each of the three off combinations, and the turn-on latency is measured on each return. This separates the truth table from the two delay counters. Faults are injected on every channel in turn, and once with the lasers already off. Each injection tells apart a correct shared latch from one that misses a channel, ignores faults while dark, or forgets a fault when the flag drops. Clear pulses are swept in width from one cycle to beyond the minimum, which pins the acceptance boundary. The relight latency after an accepted clear is also timed, so the block cannot skip its turn-on delay after a clear.

// File: rtl/laser_link_ctl.sv
module laser_link_ctl #(
  parameter int NCH     = 12,
  parameter int ON_CYC  = 100000,
  parameter int OFF_CYC = 51000,
  parameter int CLR_MIN = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_enable,
  input  logic           tx_inhibit,
  input  logic           fault_clr_n,
  input  logic [NCH-1:0] ch_fault,
  output logic [NCH-1:0] laser_en,
  output logic           fault_n,
  output logic           ready
);
  localparam int DMAX = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW   = $clog2(DMAX + 1);
  localparam int RW   = $clog2(CLR_MIN + 1);

  logic [1:0]     en_sy, inh_sy, clr_sy;
  logic [NCH-1:0] flt_s1, flt_s2;
  logic [RW-1:0]  rcnt;
  logic [CW-1:0]  cnt, lim;
  logic           lat, on_q, clr_acc, en_req, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sy  <= 2'b00;
      inh_sy <= 2'b00;
      clr_sy <= 2'b11;
      flt_s1 <= '0;
      flt_s2 <= '0;
    end else begin
      en_sy  <= {en_sy[0], tx_enable};
      inh_sy <= {inh_sy[0], tx_inhibit};
      clr_sy <= {clr_sy[0], fault_clr_n};
      flt_s1 <= ch_fault;
      flt_s2 <= flt_s1;
    end
  end

  assign clr_acc = (rcnt == RW'(CLR_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rcnt <= '0;
    else if (clr_sy[1])     rcnt <= '0;
    else if (!clr_acc)      rcnt <= rcnt + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat <= 1'b0;
    else if (clr_acc)    lat <= 1'b0;
    else if (|flt_s2)    lat <= 1'b1;
  end

  assign en_req = en_sy[1] & ~inh_sy[1] & ~lat & ~clr_acc;
  assign lim    = on_q ? CW'(OFF_CYC - 1) : CW'(ON_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else if (lat || clr_acc) begin
      on_q <= 1'b0;
      cnt  <= '0;
    end else if (en_req != on_q) begin
      if (cnt == lim) begin
        on_q <= en_req;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt <= '0;
    end
  end

  assign live     = on_q & ~lat & ~clr_acc;
  assign laser_en = {NCH{live}};
  assign ready    = live;
  assign fault_n  = ~lat;
endmodule

// File: rtl/laser_link_ctl_chk.sv
module laser_link_ctl_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] laser_en,
  input logic           fault_n,
  input logic           ready,
  input logic           clr_acc,
  input logic           en_req
);
  p_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (laser_en == '0) || (laser_en == {NCH{1'b1}}));

  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (laser_en == '0));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_acc) |=> !fault_n);

  p_clear_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(clr_acc));

  p_light_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(en_req));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (|laser_en));
endmodule

bind laser_link_ctl laser_link_ctl_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .laser_en(laser_en), .fault_n(fault_n),
  .ready(ready), .clr_acc(clr_acc), .en_req(en_req)
);

// File: tb/test_laser_link_ctl.sv
module test_laser_link_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;
  localparam int ON = 6;
  localparam int OFF = 4;
  localparam int CLR = 5;

  logic clk = 0, rst_n = 0, tx_enable = 1, tx_inhibit = 0, fault_clr_n = 1;
  logic [NCH-1:0] ch_fault = '0;
  logic [NCH-1:0] laser_en;
  logic fault_n, ready;
  int n_chk = 0, n_fail = 0;

  laser_link_ctl #(.NCH(NCH), .ON_CYC(ON), .OFF_CYC(OFF), .CLR_MIN(CLR)) i_laser_link_ctl (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_inhibit(tx_inhibit),
    .fault_clr_n(fault_clr_n), .ch_fault(ch_fault), .laser_en(laser_en),
    .fault_n(fault_n), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges_until_ready(input logic tgt, output int n);
    n = 0;
    while (n < 100) begin
      @(posedge clk); #1; n++;
      if (ready == tgt) break;
    end
  endtask

  task automatic edges_until_fault(input logic tgt, output int n);
    n = 0;
    while (n < 100) begin
      @(posedge clk); #1; n++;
      if (fault_n == tgt) break;
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(posedge clk);
    #1;
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset laser_en", int'(laser_en), 0);
    check("R10 reset fault_n", int'(fault_n), 1);
    check("R10 reset ready", int'(ready), 0);
    @(negedge clk); rst_n = 1;
    edges_until_ready(1'b1, n);
    check("R10/R3 startup latency", n, ON + 2);
    check("R1 all lit", int'(laser_en), (1 << NCH) - 1);
    check("R9 ready lit", int'(ready), 1);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tx_enable = k[0]; tx_inhibit = k[1];
      if (k == 1) begin
        idle(20);
        check("R2 on combination stays lit", int'(ready), 1);
      end else begin
        edges_until_ready(1'b0, n);
        check("R4 turn-off latency", n, OFF + 2);
        check("R1 all dark", int'(laser_en), 0);
        idle(20);
        check("R2 off combination stays dark", int'(laser_en), 0);
        @(negedge clk); tx_enable = 1; tx_inhibit = 0;
        edges_until_ready(1'b1, n);
        check("R3 turn-on latency", n, ON + 2);
      end
    end

    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); ch_fault = NCH'(1) << c;
      edges_until_fault(1'b0, n);
      check($sformatf("R5 fault latency ch%0d", c), n, 3);
      check("R5 lasers forced off", int'(laser_en), 0);
      @(negedge clk); ch_fault = '0;
      idle(10);
      check("R6 fault held", int'(fault_n), 0);
      check("R6 lasers stay off", int'(ready), 0);
      @(negedge clk); fault_clr_n = 0;
      repeat (CLR - 1) @(negedge clk);
      fault_clr_n = 1;
      idle(10);
      check("R7 short clear ignored", int'(fault_n), 0);
      @(negedge clk); fault_clr_n = 0;
      edges_until_fault(1'b1, n);
      check("R7 clear latency", n, CLR + 3);
      idle(3);
      check("R7 dark while clear held", int'(laser_en), 0);
      @(negedge clk); fault_clr_n = 1;
      edges_until_ready(1'b1, n);
      check("R8 relight latency", n, ON + 3);
    end

    @(negedge clk); tx_enable = 0;
    idle(OFF + 4);
    @(negedge clk); ch_fault = NCH'(1) << 7;
    edges_until_fault(1'b0, n);
    check("R5 fault while dark", n, 3);
    @(negedge clk); ch_fault = '0; tx_enable = 1;
    idle(ON + 6);
    check("R6 no relight while held", int'(ready), 0);

    for (int w = 1; w <= CLR + 2; w++) begin
      @(negedge clk); ch_fault = NCH'(1) << (w % NCH);
      @(negedge clk); ch_fault = '0;
      idle(5);
      @(negedge clk); fault_clr_n = 0;
      repeat (w) @(negedge clk);
      fault_clr_n = 1;
      idle(12);
      check($sformatf("R7 clear width %0d", w), int'(fault_n), (w >= CLR) ? 1 : 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule